// File: doc/BRIEF.md
# Bit-Interleaved Backplane Multiplexer

This block sits between four line-side links and a backplane. In the outbound direction it takes one PCM bit stream and one signaling bit stream from each link, eight streams in all at 2.048 Mbit/s, and merges them bit by bit into one 16.384 Mbit/s serial stream. In the inbound direction it takes an interleaved serial stream from the backplane and splits it back into the eight component streams. Each recovered bit comes with a one-clock valid strobe for its stream. A frame pulse on each side sets the position of bit 1 of the first PCM stream. Between pulses a phase counter runs free over the 2048-clock interleaved frame.

An active-low select input picks the backplane mode. When it is low, the block uses the shared serial pins. When it is high, each stream has its own dedicated pin and the serial output is held low. Serial output data and the dedicated outbound pins change on the falling clock edge. Inputs and frame pulses are sampled on the rising edge. Outbound sources are told when their bits have been taken by a take strobe, which is high during the clock that sends the first bit of each 8-bit group.

Top module: `bim_backplane_mux`

## Requirements
- R1: While reset is asserted, every output is 0, and this includes both take strobes.
- R2: In multiplexed mode (select low), the eight outbound stream bits are latched on the rising edge that starts a group. Over the next eight clocks the serial output carries them in the order PCM1, SIG1, PCM2, SIG2, PCM3, SIG3, PCM4, SIG4, which are group slots 0 to 7. The take strobe is high during slot 0. The frame-take strobe is high only during slot 0 of phase 0.
- R3: The outbound serial output changes only on the falling clock edge. Its value just after a rising edge equals its value before that edge.
- R4: When an outbound frame pulse is sampled on a rising edge, that clock becomes phase 0 (PCM1, bit 1), whatever phase the counter held before.
- R5: In multiplexed mode, an inbound serial bit sampled at phase p appears on the output of stream p mod 8 (same order as R2) two rising edges later.
- R6: In multiplexed mode, at most one inbound valid strobe is high in any clock. Stream k's strobe is high for exactly one clock in every eight, two rising edges after a bit of slot k is sampled.
- R7: When an inbound frame pulse is sampled with a serial bit, that bit is taken as phase 0 (PCM1), even if the pulse arrives in the middle of a group.
- R8: In multiplexed mode, the inbound frame marker is high together with the PCM1 strobe for the bit at phase 0. Without a new pulse, it recurs every 2048 clocks.
- R9: In dedicated mode (select high), the serial output is 0. The dedicated outbound pins copy the outbound stream inputs on each falling edge.
- R10: In multiplexed mode, the dedicated outbound pins are held at 0.
- R11: In dedicated mode, the inbound stream outputs take the dedicated inbound pins two rising edges after they are sampled. All eight valid strobes are high, the frame marker follows the sampled inbound pulse, and the serial input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz multiplex clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mux_en_n | input | 1 | Low: shared serial backplane; high: dedicated per-stream pins |
| ob_pcm | input | N_LINKS | Outbound PCM bit per link |
| ob_sig | input | N_LINKS | Outbound signaling bit per link |
| ob_fp | input | 1 | Outbound frame pulse, sampled on the rising edge |
| ob_ser | output | 1 | Outbound interleaved serial data, falling-edge updated |
| ob_take | output | 1 | Group taken: sources may present their next bits |
| ob_take_frm | output | 1 | Take strobe for the first group of a frame |
| ob_pcm_ded | output | N_LINKS | Dedicated outbound PCM pins, falling-edge updated |
| ob_sig_ded | output | N_LINKS | Dedicated outbound signaling pins, falling-edge updated |
| ib_ser | input | 1 | Inbound interleaved serial data, sampled on the rising edge |
| ib_fp | input | 1 | Inbound frame pulse, sampled on the rising edge |
| ib_pcm_ded | input | N_LINKS | Dedicated inbound PCM pins |
| ib_sig_ded | input | N_LINKS | Dedicated inbound signaling pins |
| ib_pcm | output | N_LINKS | Recovered PCM bit per link |
| ib_sig | output | N_LINKS | Recovered signaling bit per link |
| ib_pcm_vld | output | N_LINKS | One-clock valid strobe per PCM stream |
| ib_sig_vld | output | N_LINKS | One-clock valid strobe per signaling stream |
| ib_frm | output | 1 | Inbound frame marker, with the PCM1 bit 1 strobe |

## Verification
The bench builds the block with its defaults, four links and 256 bits per stream, so one interleaved frame is 2048 clocks. With that frame length, a run of about 2300 clocks after a single pulse reaches the free-running frame wrap of R8. Random and directed frame pulses then land at every group slot, including back-to-back pulses, which exercises realignment on both sides. Runs with the mode held and with the mode toggling cover both backplane modes, and also the clocks where the falling-edge mode and the two-stage inbound mode disagree.

// File: rtl/bim_pkg.sv
`timescale 1ns/1ps
package bim_pkg;

  // Backplane mode as seen on the active-low select pin.
  typedef enum logic {
    MODE_MUX = 1'b0,
    MODE_DED = 1'b1
  } bim_mode_e;

  localparam int unsigned BIM_LINKS_DEF = 4;
  localparam int unsigned BIM_BITS_DEF  = 256;

  // Streams per link: one PCM and one signaling.
  localparam int unsigned BIM_STREAMS_PER_LINK = 2;

endpackage

// File: rtl/bim_phase.sv
`timescale 1ns/1ps
module bim_phase #(
  parameter int unsigned FRAME_LEN = 2048,
  parameter int unsigned GROUP     = 8,
  localparam int unsigned PH_W     = $clog2(FRAME_LEN),
  localparam int unsigned SLOT_W   = $clog2(GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp,
  output logic [SLOT_W-1:0] slot,
  output logic              top
);

  localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_LEN - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  // A pulse forces phase 0; otherwise count and wrap at the frame end.
  always_comb begin
    if (fp) begin
      ph_d = '0;
    end else if (ph_q == LAST) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  // Reset to the last phase so no group start is signalled in reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= LAST;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign slot = ph_q[SLOT_W-1:0];
  assign top  = (ph_q == '0);

  // R4 / R7: a sampled pulse makes the following clock phase 0
  a_r4_fp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (ph_q == '0));

  // R8: without a pulse the phase steps by one and wraps at the frame end
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    !fp |=> (ph_q == (($past(ph_q) == LAST) ? '0 : $past(ph_q) + 1'b1)));

endmodule

// File: rtl/bim_tx_mux.sv
`timescale 1ns/1ps
module bim_tx_mux
  import bim_pkg::*;
#(
  parameter int unsigned N_LINKS   = 4,
  parameter int unsigned FRAME_LEN = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bim_mode_e          mode,
  input  logic               fp,
  input  logic [N_LINKS-1:0] pcm,
  input  logic [N_LINKS-1:0] sig,
  output logic               ser,
  output logic               take,
  output logic               take_frm,
  output logic [N_LINKS-1:0] pcm_ded,
  output logic [N_LINKS-1:0] sig_ded
);

  localparam int unsigned GROUP  = BIM_STREAMS_PER_LINK * N_LINKS;
  localparam int unsigned SLOT_W = $clog2(GROUP);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(GROUP - 1);

  logic [SLOT_W-1:0] slot;
  logic              top;
  logic [GROUP-1:0]  grp_in;
  logic [GROUP-1:0]  grp_q;
  logic [GROUP-1:0]  grp_d;
  logic              grp_ld;
  logic              ded;

  logic               ser_q;
  logic               ser_d;
  logic [N_LINKS-1:0] pcm_ded_q;
  logic [N_LINKS-1:0] pcm_ded_d;
  logic [N_LINKS-1:0] sig_ded_q;
  logic [N_LINKS-1:0] sig_ded_d;

  bim_phase #(
    .FRAME_LEN (FRAME_LEN),
    .GROUP     (GROUP)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .fp    (fp),
    .slot  (slot),
    .top   (top)
  );

  // Interleave order: even slots carry PCM, odd slots signaling.
  for (genvar l = 0; l < N_LINKS; l++) begin : g_order
    assign grp_in[2*l]   = pcm[l];
    assign grp_in[2*l+1] = sig[l];
  end

  assign ded = (mode == MODE_DED);

  // The next clock is slot 0 on a pulse or after the last slot.
  assign grp_ld = fp || (slot == SLOT_LAST);

  always_comb begin
    grp_d = grp_q;
    if (grp_ld) begin
      grp_d = grp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else begin
      grp_q <= grp_d;
    end
  end

  // Falling-edge launch of serial data and dedicated pins.
  always_comb begin
    if (ded) begin
      ser_d     = 1'b0;
      pcm_ded_d = pcm;
      sig_ded_d = sig;
    end else begin
      ser_d     = grp_q[slot];
      pcm_ded_d = '0;
      sig_ded_d = '0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q     <= 1'b0;
      pcm_ded_q <= '0;
      sig_ded_q <= '0;
    end else begin
      ser_q     <= ser_d;
      pcm_ded_q <= pcm_ded_d;
      sig_ded_q <= sig_ded_d;
    end
  end

  assign ser      = ser_q;
  assign pcm_ded  = pcm_ded_q;
  assign sig_ded  = sig_ded_q;
  assign take     = (slot == '0);
  assign take_frm = top;

  // R9: dedicated mode silences the serial output
  a_r9_ser_quiet: assert property (@(negedge clk) disable iff (!rst_n)
    ded |=> (ser_q == 1'b0));

  // R10: multiplexed mode parks the dedicated pins low
  a_r10_ded_quiet: assert property (@(negedge clk) disable iff (!rst_n)
    !ded |=> ((pcm_ded_q == '0) && (sig_ded_q == '0)));

  // R2: a take is never followed by another unless a pulse realigns
  a_r2_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fp) |=> !take);

endmodule

// File: rtl/bim_rx_demux.sv
`timescale 1ns/1ps
module bim_rx_demux
  import bim_pkg::*;
#(
  parameter int unsigned N_LINKS   = 4,
  parameter int unsigned FRAME_LEN = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bim_mode_e          mode,
  input  logic               ser,
  input  logic               fp,
  input  logic [N_LINKS-1:0] pcm_pin,
  input  logic [N_LINKS-1:0] sig_pin,
  output logic [N_LINKS-1:0] pcm,
  output logic [N_LINKS-1:0] sig,
  output logic [N_LINKS-1:0] pcm_vld,
  output logic [N_LINKS-1:0] sig_vld,
  output logic               frm
);

  localparam int unsigned GROUP  = BIM_STREAMS_PER_LINK * N_LINKS;
  localparam int unsigned SLOT_W = $clog2(GROUP);

  // Stage 1: sampled inputs; the phase counter tracks the sampled bit.
  logic               ser_q;
  logic               fp_q;
  logic               ded_q;
  logic [N_LINKS-1:0] pcm_pin_q;
  logic [N_LINKS-1:0] sig_pin_q;
  logic [SLOT_W-1:0]  slot;
  logic               top;

  // Stage 2: routed outputs.
  logic [N_LINKS-1:0] pcm_q, pcm_d;
  logic [N_LINKS-1:0] sig_q, sig_d;
  logic [N_LINKS-1:0] pcm_vld_q, pcm_vld_d;
  logic [N_LINKS-1:0] sig_vld_q, sig_vld_d;
  logic               frm_q, frm_d;

  bim_phase #(
    .FRAME_LEN (FRAME_LEN),
    .GROUP     (GROUP)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .fp    (fp),
    .slot  (slot),
    .top   (top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q     <= 1'b0;
      fp_q      <= 1'b0;
      ded_q     <= 1'b0;
      pcm_pin_q <= '0;
      sig_pin_q <= '0;
    end else begin
      ser_q     <= ser;
      fp_q      <= fp;
      ded_q     <= (mode == MODE_DED);
      pcm_pin_q <= pcm_pin;
      sig_pin_q <= sig_pin;
    end
  end

  always_comb begin
    pcm_d     = pcm_q;
    sig_d     = sig_q;
    pcm_vld_d = '0;
    sig_vld_d = '0;
    frm_d     = 1'b0;
    if (ded_q) begin
      pcm_d     = pcm_pin_q;
      sig_d     = sig_pin_q;
      pcm_vld_d = '1;
      sig_vld_d = '1;
      frm_d     = fp_q;
    end else begin
      for (int l = 0; l < N_LINKS; l++) begin
        if (slot == SLOT_W'(2*l)) begin
          pcm_vld_d[l] = 1'b1;
          pcm_d[l]     = ser_q;
        end
        if (slot == SLOT_W'(2*l+1)) begin
          sig_vld_d[l] = 1'b1;
          sig_d[l]     = ser_q;
        end
      end
      frm_d = top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_q     <= '0;
      sig_q     <= '0;
      pcm_vld_q <= '0;
      sig_vld_q <= '0;
      frm_q     <= 1'b0;
    end else begin
      pcm_q     <= pcm_d;
      sig_q     <= sig_d;
      pcm_vld_q <= pcm_vld_d;
      sig_vld_q <= sig_vld_d;
      frm_q     <= frm_d;
    end
  end

  assign pcm     = pcm_q;
  assign sig     = sig_q;
  assign pcm_vld = pcm_vld_q;
  assign sig_vld = sig_vld_q;
  assign frm     = frm_q;

  // R6: in multiplexed mode no two streams are strobed together
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ded_q) |-> $onehot0({pcm_vld_q, sig_vld_q}));

  // R8: the frame marker rides with the first PCM stream
  a_r8_frm_pcm1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q && !$past(ded_q)) |-> pcm_vld_q[0]);

  // R11: dedicated mode strobes every stream each clock
  a_r11_ded_all_vld: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ded_q) |-> (&{pcm_vld_q, sig_vld_q}));

endmodule

// File: rtl/bim_backplane_mux.sv
`timescale 1ns/1ps
module bim_backplane_mux
  import bim_pkg::*;
#(
  parameter int unsigned N_LINKS        = BIM_LINKS_DEF,
  parameter int unsigned BITS_PER_FRAME = BIM_BITS_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mux_en_n,
  input  logic [N_LINKS-1:0] ob_pcm,
  input  logic [N_LINKS-1:0] ob_sig,
  input  logic               ob_fp,
  output logic               ob_ser,
  output logic               ob_take,
  output logic               ob_take_frm,
  output logic [N_LINKS-1:0] ob_pcm_ded,
  output logic [N_LINKS-1:0] ob_sig_ded,
  input  logic               ib_ser,
  input  logic               ib_fp,
  input  logic [N_LINKS-1:0] ib_pcm_ded,
  input  logic [N_LINKS-1:0] ib_sig_ded,
  output logic [N_LINKS-1:0] ib_pcm,
  output logic [N_LINKS-1:0] ib_sig,
  output logic [N_LINKS-1:0] ib_pcm_vld,
  output logic [N_LINKS-1:0] ib_sig_vld,
  output logic               ib_frm
);

  // Interleaved frame length; must be a power of two.
  localparam int unsigned FRAME_LEN = BITS_PER_FRAME * BIM_STREAMS_PER_LINK * N_LINKS;

  logic      rst_meta_q;
  logic      rst_sync_q;
  bim_mode_e mode;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign mode = bim_mode_e'(mux_en_n);

  bim_tx_mux #(
    .N_LINKS   (N_LINKS),
    .FRAME_LEN (FRAME_LEN)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .mode     (mode),
    .fp       (ob_fp),
    .pcm      (ob_pcm),
    .sig      (ob_sig),
    .ser      (ob_ser),
    .take     (ob_take),
    .take_frm (ob_take_frm),
    .pcm_ded  (ob_pcm_ded),
    .sig_ded  (ob_sig_ded)
  );

  bim_rx_demux #(
    .N_LINKS   (N_LINKS),
    .FRAME_LEN (FRAME_LEN)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .mode    (mode),
    .ser     (ib_ser),
    .fp      (ib_fp),
    .pcm_pin (ib_pcm_ded),
    .sig_pin (ib_sig_ded),
    .pcm     (ib_pcm),
    .sig     (ib_sig),
    .pcm_vld (ib_pcm_vld),
    .sig_vld (ib_sig_vld),
    .frm     (ib_frm)
  );

endmodule

// File: tb/test_bim_backplane_mux.sv
`timescale 1ns/1ps
module test_bim_backplane_mux;

  localparam int NL   = 4;
  localparam int BPF  = 256;
  localparam int GRP  = 2 * NL;
  localparam int FLEN = BPF * GRP;

  typedef struct packed {
    logic          men;
    logic          ofp;
    logic [NL-1:0] opcm;
    logic [NL-1:0] osig;
    logic          ifp;
    logic          iser;
    logic [NL-1:0] ipcm;
    logic [NL-1:0] isig;
  } drv_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          mux_en_n;
  logic [NL-1:0] ob_pcm, ob_sig;
  logic          ob_fp;
  logic          ob_ser, ob_take, ob_take_frm;
  logic [NL-1:0] ob_pcm_ded, ob_sig_ded;
  logic          ib_ser, ib_fp;
  logic [NL-1:0] ib_pcm_ded, ib_sig_ded;
  logic [NL-1:0] ib_pcm, ib_sig, ib_pcm_vld, ib_sig_vld;
  logic          ib_frm;

  bim_backplane_mux #(.N_LINKS(NL), .BITS_PER_FRAME(BPF)) i_bim_backplane_mux (
    .clk(clk), .rst_n(rst_n), .mux_en_n(mux_en_n),
    .ob_pcm(ob_pcm), .ob_sig(ob_sig), .ob_fp(ob_fp),
    .ob_ser(ob_ser), .ob_take(ob_take), .ob_take_frm(ob_take_frm),
    .ob_pcm_ded(ob_pcm_ded), .ob_sig_ded(ob_sig_ded),
    .ib_ser(ib_ser), .ib_fp(ib_fp),
    .ib_pcm_ded(ib_pcm_ded), .ib_sig_ded(ib_sig_ded),
    .ib_pcm(ib_pcm), .ib_sig(ib_sig),
    .ib_pcm_vld(ib_pcm_vld), .ib_sig_vld(ib_sig_vld), .ib_frm(ib_frm)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   in_reset;
  drv_t cur, p1, p2;
  int   tph, iph;
  bit   oval, ival;
  logic [GRP-1:0] grpm;
  logic last_ser;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [GRP-1:0] build_grp(input logic [NL-1:0] p, input logic [NL-1:0] s);
    logic [GRP-1:0] g;
    for (int l = 0; l < NL; l++) begin
      g[2*l]   = p[l];
      g[2*l+1] = s[l];
    end
    return g;
  endfunction

  function automatic drv_t gen(input bit men, input int omod, input int imod);
    drv_t d;
    d.men  = men;
    d.opcm = NL'($urandom);
    d.osig = NL'($urandom);
    d.iser = 1'($urandom);
    d.ipcm = NL'($urandom);
    d.isig = NL'($urandom);
    d.ofp  = (omod > 0) ? ($urandom_range(omod - 1) == 0) : 1'b0;
    d.ifp  = (imod > 0) ? ($urandom_range(imod - 1) == 0) : 1'b0;
    return d;
  endfunction

  task automatic apply(input drv_t d);
    mux_en_n   = d.men;
    ob_fp      = d.ofp;
    ob_pcm     = d.opcm;
    ob_sig     = d.osig;
    ib_fp      = d.ifp;
    ib_ser     = d.iser;
    ib_pcm_ded = d.ipcm;
    ib_sig_ded = d.isig;
  endtask

  task automatic step(input drv_t nxt);
    bit   ival_old;
    int   iph_old;
    int   sl;
    string r;
    logic [NL-1:0] ep, es;
    @(posedge clk);
    #2;
    chk("R3", ob_ser, last_ser);
    p2 = p1;
    p1 = cur;
    cur = nxt;
    apply(cur);
    // outbound model for the edge just taken (inputs of p1)
    if (p1.ofp) begin tph = 0; oval = 1; end
    else tph = (tph + 1) % FLEN;
    if (tph % GRP == 0) grpm = build_grp(p1.opcm, p1.osig);
    // inbound model: outputs now reflect the bit sampled one edge earlier
    ival_old = ival;
    iph_old  = iph;
    if (p1.ifp) begin iph = 0; ival = 1; end
    else iph = (iph + 1) % FLEN;
    #6;
    if (in_reset) begin
      chk("R1", {ob_ser, ob_take, ob_take_frm, ob_pcm_ded, ob_sig_ded}, '0);
      chk("R1", {ib_pcm, ib_sig, ib_pcm_vld, ib_sig_vld, ib_frm}, '0);
    end else begin
      if (oval) begin
        r = p1.ofp ? "R4" : "R2";
        chk(r, ob_take, 32'(tph % GRP == 0));
        chk(r, ob_take_frm, 32'(tph == 0));
        if (cur.men) chk("R9", ob_ser, 0);
        else         chk(r, ob_ser, grpm[tph % GRP]);
      end
      if (cur.men) chk("R9", {ob_pcm_ded, ob_sig_ded}, {cur.opcm, cur.osig});
      else         chk("R10", {ob_pcm_ded, ob_sig_ded}, 0);
      if (ival_old) begin
        if (p2.men) begin
          chk("R11", {ib_pcm, ib_sig}, {p2.ipcm, p2.isig});
          chk("R11", {ib_pcm_vld, ib_sig_vld}, {2*NL{1'b1}});
          chk("R11", ib_frm, p2.ifp);
        end else begin
          sl = iph_old % GRP;
          ep = '0;
          es = '0;
          if (sl % 2 == 0) ep[sl/2] = 1'b1;
          else             es[sl/2] = 1'b1;
          chk(p2.ifp ? "R7" : "R6", {ib_pcm_vld, ib_sig_vld}, {ep, es});
          chk("R8", ib_frm, 32'(iph_old == 0));
          if (sl % 2 == 0) chk("R5", ib_pcm[sl/2], p2.iser);
          else             chk("R5", ib_sig[sl/2], p2.iser);
        end
      end
    end
    last_ser = ob_ser;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drv_t d;
    bit   men;
    void'($urandom(32'd4711));
    rst_n    = 1'b0;
    in_reset = 1'b1;
    cur = '0; p1 = '0; p2 = '0;
    apply(cur);
    tph = 0; iph = 0; oval = 0; ival = 0; grpm = '0; last_ser = 1'b0;

    // R1: reset state under random data without pulses
    for (int k = 0; k < 6; k++) step(gen(1'b0, 0, 0));
    @(posedge clk);
    #2 rst_n = 1'b1;
    in_reset = 1'b0;
    for (int k = 0; k < 4; k++) step(gen(1'b0, 0, 0));

    men = 1'b0;
    for (int n = 0; n < 4600; n++) begin
      if (n < 2300) begin
        // single alignment then free running past a frame wrap (R8)
        d = gen(1'b0, 0, 0);
        if (n == 0) begin d.ofp = 1'b1; d.ifp = 1'b1; end
        if (n == 13) d.ofp = 1'b1;   // outbound realign mid-group (R4)
      end else if (n < 3600) begin
        d = gen(1'b0, 200, 200);
        if (n == 2300 || n == 2301) begin d.ofp = 1'b1; d.ifp = 1'b1; end
        if (n == 2310) d.ifp = 1'b1; // inbound realign mid-group (R7)
      end else if (n < 4000) begin
        d = gen(1'b1, 150, 150);
      end else begin
        if ($urandom_range(39) == 0) men = ~men;
        d = gen(men, 100, 100);
      end
      step(d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule